// File: doc/BRIEF.md
# Byte-Lane Realignment Reservation Row

This block is one reservation row of an 8-bit-lane function unit. The row has two operand latches. Each latch accepts a full 32-bit register word together with the index of the byte that holds the element the row needs. That byte is usually not in the row's own lane, which is called its home lane. The row corrects this itself. It sends the latched word through a small any-to-any byte crossbar and writes the permuted word back into the same latch. After that, the wanted element sits in the home lane and the bytes around it keep their relative order.

The two sources share one crossbar. When both need realignment, source 1 goes through first and source 2 waits one cycle. A source whose element already sits in the home lane skips the crossbar. The row raises ready once both operands are aligned. When the issue strobe is taken, both latches return to empty.

For a 16-bit operation, two neighbouring rows pair up. In paired mode a row reports ready only when its partner is also ready.

Top module: `lane_realign_row`

## Requirements
- R1: After reset, both operand latches are empty and hold zero words, and ready, own-ready and both aligned flags are low.
- R2: A load strobe is accepted only while its latch is empty. A load into an occupied latch changes neither the latched word nor its alignment state.
- R3: A source whose element byte index equals the home lane (parameter, default 2) is reported aligned right after the clock edge that loads it, and its word is kept unchanged.
- R4: A source whose element byte index e differs from the home lane H is permuted so that output byte k (bits 8k+7:8k) takes input byte (k - H + e) mod 4. When the crossbar is free, the source is reported aligned after the second clock edge following its load edge.
- R5: The crossbar serves at most one source per cycle, and source 1 has priority. When both sources load misaligned on the same edge, source 2 is aligned one edge later than source 1.
- R6: Own-ready is high exactly when both sources are aligned. Ready is never high unless both sources are aligned.
- R7: An issue strobe taken while ready is high returns both latches to empty on the next edge. An issue strobe while ready is low has no effect.
- R8: With pairing enabled, ready follows own-ready only while the partner's ready input is high. With pairing disabled, ready equals own-ready.
- R9: Each operand byte output is the home-lane byte of its latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src1_wr_i | input | 1 | Load strobe for source 1 |
| src1_data_i | input | 32 | Source 1 register word |
| src1_lane_i | input | 2 | Byte index of the source 1 element within the word |
| src2_wr_i | input | 1 | Load strobe for source 2 |
| src2_data_i | input | 32 | Source 2 register word |
| src2_lane_i | input | 2 | Byte index of the source 2 element within the word |
| issue_i | input | 1 | Issue strobe from the scheduler |
| pair_i | input | 1 | Row is paired with its neighbour for a 16-bit operation |
| peer_rdy_i | input | 1 | Own-ready of the partner row |
| rdy_o | output | 1 | Row ready to issue |
| own_rdy_o | output | 1 | Both local sources aligned (sent to the partner) |
| src1_aligned_o | output | 1 | Source 1 aligned |
| src2_aligned_o | output | 1 | Source 2 aligned |
| src1_word_o | output | 32 | Source 1 latch contents |
| src2_word_o | output | 32 | Source 2 latch contents |
| op1_o | output | 8 | Source 1 home-lane byte |
| op2_o | output | 8 | Source 2 home-lane byte |

## Verification
The bench sweeps all sixteen combinations of the two element indices with two byte patterns. For each combination it measures the edge on which each source becomes aligned and compares the full permuted word with a rotation computed arithmetically in the bench. A crossbar with a wrong select offset would put the wrong byte in the home lane or rotate the other bytes the wrong way. A broken arbiter would align source 2 too early or corrupt it with source 1's data. A skip path that still went through the crossbar would add two cycles. Separate sequences load into an occupied latch, issue while not ready, and toggle the partner's ready in paired mode; these catch a latch that can be overwritten, an issue strobe that clears too eagerly, and pairing logic that ignores the partner.

// File: rtl/lrr_pkg.sv
`timescale 1ns/1ps
package lrr_pkg;
  typedef enum logic [1:0] {
    SRC_EMPTY   = 2'd0,
    SRC_LATCHED = 2'd1,
    SRC_SHUF    = 2'd2,
    SRC_ALIGNED = 2'd3
  } src_state_e;
endpackage

// File: rtl/lrr_byte_xbar.sv
`timescale 1ns/1ps
module lrr_byte_xbar #(
  parameter int LANES  = 4,
  parameter int BYTE_W = 8,
  localparam int WORD_W = LANES * BYTE_W,
  localparam int SEL_W  = $clog2(LANES)
) (
  input  logic [WORD_W-1:0]       word_i,
  input  logic [LANES*SEL_W-1:0]  sel_i,
  output logic [WORD_W-1:0]       word_o
);
  for (genvar k = 0; k < LANES; k++) begin : g_out
    logic [SEL_W-1:0]  sel;
    logic [BYTE_W-1:0] pick;
    assign sel = sel_i[k*SEL_W +: SEL_W];
    always_comb begin
      pick = '0;
      for (int j = 0; j < LANES; j++) begin
        if (sel == SEL_W'(j)) pick = word_i[j*BYTE_W +: BYTE_W];
      end
    end
    assign word_o[k*BYTE_W +: BYTE_W] = pick;
  end
endmodule

// File: rtl/lrr_shuffle_unit.sv
`timescale 1ns/1ps
module lrr_shuffle_unit #(
  parameter int LANES     = 4,
  parameter int BYTE_W    = 8,
  parameter int HOME_LANE = 2,
  localparam int WORD_W = LANES * BYTE_W,
  localparam int SEL_W  = $clog2(LANES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [SEL_W-1:0]  lane_i,
  output logic [WORD_W-1:0] res_o
);
  localparam logic [SEL_W-1:0] HOME = SEL_W'(HOME_LANE);

  logic [LANES*SEL_W-1:0] sel;
  logic [WORD_W-1:0]      perm;
  logic [WORD_W-1:0]      res_q;

  // output byte k draws input byte (k - home + element) modulo LANES
  for (genvar k = 0; k < LANES; k++) begin : g_sel
    assign sel[k*SEL_W +: SEL_W] = SEL_W'(k) + lane_i - HOME;
  end

  lrr_byte_xbar #(.LANES(LANES), .BYTE_W(BYTE_W)) u_xbar (
    .word_i (word_i),
    .sel_i  (sel),
    .word_o (perm)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   res_q <= '0;
    else if (go_i) res_q <= perm;
  end

  assign res_o = res_q;
endmodule

// File: rtl/lrr_src_slot.sv
`timescale 1ns/1ps
module lrr_src_slot
  import lrr_pkg::*;
#(
  parameter int LANES     = 4,
  parameter int BYTE_W    = 8,
  parameter int HOME_LANE = 2,
  localparam int WORD_W = LANES * BYTE_W,
  localparam int SEL_W  = $clog2(LANES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic [SEL_W-1:0]  lane_i,
  input  logic              gnt_i,
  input  logic [WORD_W-1:0] fwd_data_i,
  input  logic              clr_i,
  output logic              req_o,
  output logic              aligned_o,
  output logic [WORD_W-1:0] word_o,
  output logic [SEL_W-1:0]  lane_o
);
  localparam logic [SEL_W-1:0] HOME = SEL_W'(HOME_LANE);

  src_state_e        state_q;
  logic [WORD_W-1:0] word_q;
  logic [SEL_W-1:0]  lane_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SRC_EMPTY;
      word_q  <= '0;
      lane_q  <= '0;
    end else if (clr_i) begin
      state_q <= SRC_EMPTY;
      word_q  <= '0;
      lane_q  <= '0;
    end else begin
      unique case (state_q)
        SRC_EMPTY: if (wr_i) begin
          word_q  <= data_i;
          lane_q  <= lane_i;
          state_q <= (lane_i == HOME) ? SRC_ALIGNED : SRC_LATCHED;
        end
        SRC_LATCHED: if (gnt_i) state_q <= SRC_SHUF;
        SRC_SHUF: begin
          // forwarded shuffle result lands back in this latch
          word_q  <= fwd_data_i;
          lane_q  <= HOME;
          state_q <= SRC_ALIGNED;
        end
        SRC_ALIGNED: state_q <= SRC_ALIGNED;
        default:     state_q <= SRC_EMPTY;
      endcase
    end
  end

  assign req_o     = (state_q == SRC_LATCHED);
  assign aligned_o = (state_q == SRC_ALIGNED);
  assign word_o    = word_q;
  assign lane_o    = lane_q;
endmodule

// File: rtl/lane_realign_row.sv
`timescale 1ns/1ps
module lane_realign_row #(
  parameter int LANES     = 4,
  parameter int BYTE_W    = 8,
  parameter int HOME_LANE = 2,
  localparam int WORD_W = LANES * BYTE_W,
  localparam int SEL_W  = $clog2(LANES),
  localparam int NSRC   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              src1_wr_i,
  input  logic [WORD_W-1:0] src1_data_i,
  input  logic [SEL_W-1:0]  src1_lane_i,
  input  logic              src2_wr_i,
  input  logic [WORD_W-1:0] src2_data_i,
  input  logic [SEL_W-1:0]  src2_lane_i,
  input  logic              issue_i,
  input  logic              pair_i,
  input  logic              peer_rdy_i,
  output logic              rdy_o,
  output logic              own_rdy_o,
  output logic              src1_aligned_o,
  output logic              src2_aligned_o,
  output logic [WORD_W-1:0] src1_word_o,
  output logic [WORD_W-1:0] src2_word_o,
  output logic [BYTE_W-1:0] op1_o,
  output logic [BYTE_W-1:0] op2_o
);
  logic [NSRC-1:0]              wr;
  logic [NSRC-1:0][WORD_W-1:0]  din;
  logic [NSRC-1:0][SEL_W-1:0]   lin;
  logic [NSRC-1:0]              req;
  logic [NSRC-1:0]              gnt;
  logic [NSRC-1:0]              aligned;
  logic [NSRC-1:0][WORD_W-1:0]  word;
  logic [NSRC-1:0][SEL_W-1:0]   lane;
  logic [WORD_W-1:0]            shuf_in;
  logic [SEL_W-1:0]             shuf_lane;
  logic [WORD_W-1:0]            shuf_res;
  logic                         fire;

  assign wr  = {src2_wr_i, src1_wr_i};
  assign din = {src2_data_i, src1_data_i};
  assign lin = {src2_lane_i, src1_lane_i};

  // fixed priority: lower index (src1) wins the shared crossbar
  always_comb begin
    gnt = '0;
    for (int s = 0; s < NSRC; s++) begin
      if (req[s] && gnt == '0) gnt[s] = 1'b1;
    end
  end

  always_comb begin
    shuf_in   = '0;
    shuf_lane = '0;
    for (int s = 0; s < NSRC; s++) begin
      if (gnt[s]) begin
        shuf_in   = word[s];
        shuf_lane = lane[s];
      end
    end
  end

  assign own_rdy_o = &aligned;
  assign rdy_o     = own_rdy_o && (!pair_i || peer_rdy_i);
  assign fire      = issue_i && rdy_o;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    lrr_src_slot #(
      .LANES(LANES), .BYTE_W(BYTE_W), .HOME_LANE(HOME_LANE)
    ) u_slot (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_i       (wr[s]),
      .data_i     (din[s]),
      .lane_i     (lin[s]),
      .gnt_i      (gnt[s]),
      .fwd_data_i (shuf_res),
      .clr_i      (fire),
      .req_o      (req[s]),
      .aligned_o  (aligned[s]),
      .word_o     (word[s]),
      .lane_o     (lane[s])
    );
  end

  lrr_shuffle_unit #(
    .LANES(LANES), .BYTE_W(BYTE_W), .HOME_LANE(HOME_LANE)
  ) u_shuf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .go_i   (|gnt),
    .word_i (shuf_in),
    .lane_i (shuf_lane),
    .res_o  (shuf_res)
  );

  assign src1_aligned_o = aligned[0];
  assign src2_aligned_o = aligned[1];
  assign src1_word_o    = word[0];
  assign src2_word_o    = word[1];
  assign op1_o          = word[0][HOME_LANE*BYTE_W +: BYTE_W];
  assign op2_o          = word[1][HOME_LANE*BYTE_W +: BYTE_W];
endmodule

// File: rtl/lrr_checker.sv
`timescale 1ns/1ps
module lrr_checker #(
  parameter int WORD_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rdy_o,
  input logic              own_rdy_o,
  input logic              src1_aligned_o,
  input logic              src2_aligned_o,
  input logic              issue_i,
  input logic              pair_i,
  input logic              peer_rdy_i,
  input logic [WORD_W-1:0] src1_word_o,
  input logic [1:0]        gnt
);
  assert_rdy_needs_both_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_o |-> (src1_aligned_o && src2_aligned_o));

  assert_issue_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_i && rdy_o) |=> (!src1_aligned_o && !src2_aligned_o));

  assert_one_shuffle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt));

  assert_pair_blocks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pair_i && !peer_rdy_i) |-> !rdy_o);

  assert_aligned_holds_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src1_aligned_o && !(issue_i && rdy_o)) |=> (src1_aligned_o && $stable(src1_word_o)));

  assert_own_rdy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    own_rdy_o |-> (src1_aligned_o && src2_aligned_o));
endmodule

bind lane_realign_row lrr_checker u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .rdy_o          (rdy_o),
  .own_rdy_o      (own_rdy_o),
  .src1_aligned_o (src1_aligned_o),
  .src2_aligned_o (src2_aligned_o),
  .issue_i        (issue_i),
  .pair_i         (pair_i),
  .peer_rdy_i     (peer_rdy_i),
  .src1_word_o    (src1_word_o),
  .gnt            (gnt)
);

// File: tb/sim_lane_realign_row.sv
`timescale 1ns/1ps
module sim_lane_realign_row;
  localparam int HOME = 2;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        src1_wr_i = 1'b0, src2_wr_i = 1'b0;
  logic [31:0] src1_data_i = '0, src2_data_i = '0;
  logic [1:0]  src1_lane_i = '0, src2_lane_i = '0;
  logic        issue_i = 1'b0, pair_i = 1'b0, peer_rdy_i = 1'b0;
  logic        rdy_o, own_rdy_o, src1_aligned_o, src2_aligned_o;
  logic [31:0] src1_word_o, src2_word_o;
  logic [7:0]  op1_o, op2_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  lane_realign_row #(.LANES(4), .BYTE_W(8), .HOME_LANE(HOME)) u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(input logic [31:0] w, input int e);
    logic [31:0] r;
    for (int k = 0; k < 4; k++) r[8*k +: 8] = w[8*((k - HOME + e + 4) % 4) +: 8];
    return r;
  endfunction

  function automatic logic [31:0] pattern(input int seed);
    logic [31:0] r;
    for (int k = 0; k < 4; k++) r[8*k +: 8] = 8'(16 * k + 3 * seed + 1);
    return r;
  endfunction

  // load both sources on the next edge; returns at the first sample after it
  task automatic run_case(input logic [31:0] w1, input int e1,
                          input logic [31:0] w2, input int e2);
    int t1 = 0, t2 = 0;
    int x1, x2;
    src1_wr_i = 1'b1; src1_data_i = w1; src1_lane_i = 2'(e1);
    src2_wr_i = 1'b1; src2_data_i = w2; src2_lane_i = 2'(e2);
    @(negedge clk_i);
    src1_wr_i = 1'b0; src2_wr_i = 1'b0;
    for (int obs = 1; obs <= 5; obs++) begin
      if (src1_aligned_o && t1 == 0) t1 = obs;
      if (src2_aligned_o && t2 == 0) t2 = obs;
      chk("R6 rdy vs aligned", {31'd0, rdy_o}, {31'd0, src1_aligned_o & src2_aligned_o});
      if (obs < 5) @(negedge clk_i);
    end
    x1 = (e1 == HOME) ? 1 : 3;
    x2 = (e2 == HOME) ? 1 : ((e1 == HOME) ? 3 : 4);
    chk(e1 == HOME ? "R3 src1 latency" : "R4 src1 latency", t1, x1);
    chk(e2 == HOME ? "R3 src2 latency" : "R5 src2 latency", t2, x2);
    chk("R4 src1 word", src1_word_o, exp_word(w1, e1));
    chk("R4 src2 word", src2_word_o, exp_word(w2, e2));
    chk("R9 op1 byte", {24'd0, op1_o}, {24'd0, w1[8*e1 +: 8]});
    chk("R9 op2 byte", {24'd0, op2_o}, {24'd0, w2[8*e2 +: 8]});
    issue_i = 1'b1;
    @(negedge clk_i);
    issue_i = 1'b0;
    chk("R7 cleared", {30'd0, src1_aligned_o, src2_aligned_o}, 32'd0);
  endtask

  initial begin
    logic [31:0] wa, wb;
    @(negedge clk_i);
    chk("R1 rdy", {30'd0, rdy_o, own_rdy_o}, 32'd0);
    chk("R1 aligned", {30'd0, src1_aligned_o, src2_aligned_o}, 32'd0);
    chk("R1 words", src1_word_o | src2_word_o, 32'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int s = 0; s < 2; s++)
      for (int e1 = 0; e1 < 4; e1++)
        for (int e2 = 0; e2 < 4; e2++)
          run_case(pattern(s * 7 + e1), e1, ~pattern(s + e2) ^ 32'h5a5a0000, e2);

    // R2: overwrite attempt on an occupied latch
    wa = 32'hd4c3b2a1;
    wb = 32'h11223344;
    src1_wr_i = 1'b1; src1_data_i = wa; src1_lane_i = 2'd1;
    @(negedge clk_i);
    src1_data_i = wb; src1_lane_i = 2'd2;
    @(negedge clk_i);
    src1_wr_i = 1'b0;
    repeat (4) @(negedge clk_i);
    chk("R2 occupied latch kept", src1_word_o, exp_word(wa, 1));
    chk("R2 still aligned", {31'd0, src1_aligned_o}, 32'd1);
    chk("R6 one source not ready", {30'd0, rdy_o, own_rdy_o}, 32'd0);
    // R7: issue without ready is ignored
    issue_i = 1'b1;
    @(negedge clk_i);
    issue_i = 1'b0;
    chk("R7 ignored issue", {31'd0, src1_aligned_o}, 32'd1);
    chk("R7 ignored issue word", src1_word_o, exp_word(wa, 1));
    src2_wr_i = 1'b1; src2_data_i = wb; src2_lane_i = 2'd2;
    @(negedge clk_i);
    src2_wr_i = 1'b0;
    chk("R6 both aligned", {30'd0, rdy_o, own_rdy_o}, 32'd3);
    // R8 pairing
    pair_i = 1'b1; peer_rdy_i = 1'b0;
    #1;
    chk("R8 partner not ready", {30'd0, rdy_o, own_rdy_o}, 32'd1);
    peer_rdy_i = 1'b1;
    #1;
    chk("R8 partner ready", {31'd0, rdy_o}, 32'd1);
    @(negedge clk_i);
    peer_rdy_i = 1'b0;
    issue_i = 1'b1;
    @(negedge clk_i);
    issue_i = 1'b0;
    chk("R8 blocked issue keeps operands", {30'd0, src1_aligned_o, src2_aligned_o}, 32'd3);
    peer_rdy_i = 1'b1;
    issue_i = 1'b1;
    @(negedge clk_i);
    issue_i = 1'b0;
    pair_i = 1'b0; peer_rdy_i = 1'b0;
    chk("R7 paired issue clears", {30'd0, src1_aligned_o, src2_aligned_o}, 32'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule